// File: doc/BRIEF.md
# Tagged Shared Reorder Request Queue

This block is one shared request buffer that sits in front of a memory port. Several initiators feed it through an interconnect. Every request carries a tag equal to the ID of the initiator that sent it, plus an address, a read/write bit and a 2-bit service class. Requests are stored in arrival order. They can leave in any order the selector chooses, with one exception: two requests that share a tag always leave in the order they arrived.

Each cycle the selector looks at every occupied slot, so its fan-in equals the depth. A slot is eligible when no older queued entry has the same tag. Among the eligible slots, the highest class wins, and the oldest wins a tie. The queue has one ready signal toward the network. That signal drops only when every slot is occupied, whatever class the stored traffic has. Removing an entry closes the gap at once, so slot 0 always holds the oldest entry.

Top module: `rsq_tagged_queue`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Its tag, address, write bit and class later appear unchanged on the `mem_*` outputs.
- R2: Entries with the same tag leave in arrival order, whatever their classes.
- R3: An entry may leave ahead of an older entry that has a different tag.
- R4: `req_ready` is low exactly when DEPTH entries are held. A request offered while the queue is full is not taken and does not change what is presented.
- R5: After reset the queue is empty (`req_ready`=1, `mem_valid`=0). `mem_valid` is high exactly when at least one entry is held.
- R6: Class codes rank by numeric value: 2 is priority, 1 is controlled bandwidth, 0 is best effort, and 3 ranks above 2. The presented entry has the highest class among the eligible entries.
- R7: Among eligible entries of the same class, the oldest is presented.
- R8: A removal frees its slot for the next cycle. When the queue is not full, taking one request and removing one in the same cycle keeps the occupancy unchanged.
- R9: Tag 0 is ordered exactly like any other tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Queue can take a request (not full) |
| req_tag | input | TAG_W | Initiator ID used as the ordering tag |
| req_addr | input | ADDR_W | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cls | input | 2 | Service class code |
| mem_valid | output | 1 | An entry is presented downstream |
| mem_ready | input | 1 | Downstream takes the presented entry |
| mem_tag | output | TAG_W | Tag of the presented entry |
| mem_addr | output | ADDR_W | Address of the presented entry |
| mem_we | output | 1 | Write bit of the presented entry |
| mem_cls | output | 2 | Class of the presented entry |

## Verification
The assertions assume the following about the inputs:
- Upstream never counts on a request being taken while `req_ready` is low.
- Downstream may stall for any number of cycles.
- The presented entry may change while `mem_valid` is high and `mem_ready` is low, because a newly arrived entry can outrank it.

The stimulus drives tags from a small set so that same-tag chains form often. It mixes all four class codes. It sweeps the drain probability so that the queue runs both empty and full. A reference queue in the bench follows the ready/valid rules and predicts the presented entry every cycle.

// File: rtl/rsq_pkg.sv
// Package: shared class codes and helpers for the tagged reorder queue.
// Assumes class codes compare by numeric value (higher wins).
package rsq_pkg;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        QOS_BEST  = 2'd0,
        QOS_BW    = 2'd1,
        QOS_PRIO  = 2'd2,
        QOS_URGENT = 2'd3
    } qos_e;

    // Returns 1 when class a strictly outranks class b.
    function automatic logic qos_beats(input logic [CLS_W-1:0] a, input logic [CLS_W-1:0] b);
        return a > b;
    endfunction
endpackage

// File: rtl/rsq_slots.sv
// Module: age-ordered slot array. Slot 0 is the oldest entry. Occupied
// slots are always packed at the low end. A removal shifts the younger
// entries down by one, and a new entry lands just above the last
// surviving one. Assumes enq is only raised when the array is not full.
module rsq_slots
    import rsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq,
    input  logic [TAG_W-1:0]              enq_tag,
    input  logic [ADDR_W-1:0]             enq_addr,
    input  logic                          enq_we,
    input  logic [CLS_W-1:0]              enq_cls,
    input  logic                          deq,
    input  logic [IDX_W-1:0]              deq_idx,
    output logic [DEPTH-1:0]              vld,
    output logic [DEPTH-1:0][TAG_W-1:0]   tags,
    output logic [DEPTH-1:0][ADDR_W-1:0]  addrs,
    output logic [DEPTH-1:0]              wes,
    output logic [DEPTH-1:0][CLS_W-1:0]   clss,
    output logic                          full
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wpos;

    // Write position once this cycle's removal has been applied.
    assign wpos = cnt - CNT_W'(deq);
    assign full = (cnt == CNT_W'(DEPTH));

    // Occupancy flags derived from the packed count.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld[i] = (cnt > CNT_W'(i));
        end
    end

    // Occupancy counter: plus one per accept, minus one per removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(enq) - CNT_W'(deq);
        end
    end

    // Payload storage: close the gap left by a removal, then write the arrival.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (deq && (IDX_W'(i) >= deq_idx)) begin
                tags[i]  <= tags[i+1];
                addrs[i] <= addrs[i+1];
                wes[i]   <= wes[i+1];
                clss[i]  <= clss[i+1];
            end
        end
        if (enq) begin
            tags[wpos[IDX_W-1:0]]  <= enq_tag;
            addrs[wpos[IDX_W-1:0]] <= enq_addr;
            wes[wpos[IDX_W-1:0]]   <= enq_we;
            clss[wpos[IDX_W-1:0]]  <= enq_cls;
        end
    end

    // R4: an accept never happens when every slot is taken.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        enq |-> (cnt != CNT_W'(DEPTH)));

    // R8: an accept and a removal in the same cycle leave the count unchanged.
    a_r8_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && deq) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rsq_elig.sv
// Module: per-slot ordering check. A slot is eligible when it is occupied
// and no older occupied slot carries the same tag. Assumes slot index
// equals age rank (lower index = older).
module rsq_elig #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    output logic [DEPTH-1:0]            elig
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic blocked;
        // Scan all older slots for a matching tag.
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < s; j++) begin
                if (vld[j] && (tags[j] == tags[s])) blocked = 1'b1;
            end
        end
        assign elig[s] = vld[s] && !blocked;
    end

    // R2: the oldest entry can never be held back by ordering.
    a_r2_head_free: assert property (@(posedge clk) disable iff (!rst_n)
        vld[0] |-> elig[0]);
endmodule

// File: rtl/rsq_pick.sv
// Module: selector. Picks the eligible slot with the highest class, and the
// lowest index (the oldest) among equals. Output is a one-hot grant. Fan-in
// is the full depth.
module rsq_pick
    import rsq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            elig,
    input  logic [DEPTH-1:0][CLS_W-1:0] clss,
    output logic [DEPTH-1:0]            grant,
    output logic                        any
);
    logic [IDX_W-1:0] win;
    logic [CLS_W-1:0] win_cls;

    // Walk from youngest to oldest so that a tie keeps the older slot.
    always_comb begin
        any     = 1'b0;
        win     = '0;
        win_cls = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i] && (!any || !qos_beats(win_cls, clss[i]))) begin
                any     = 1'b1;
                win     = IDX_W'(i);
                win_cls = clss[i];
            end
        end
    end

    // Turn the winning index into a one-hot grant.
    always_comb begin
        grant = '0;
        if (any) grant[win] = 1'b1;
    end

    // R5: at most one slot is granted, and only when a winner exists.
    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));

    // R2: a granted slot is always one that ordering allows.
    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig) == '0);

    for (genvar s = 0; s < DEPTH; s++) begin : g_chk
        // R6: no eligible slot outranks the presented one.
        a_r6_class_top: assert property (@(posedge clk) disable iff (!rst_n)
            (elig[s] && grant != '0) |-> !qos_beats(clss[s], win_cls));
    end
endmodule

// File: rtl/rsq_tagged_queue.sv
// Module: top of the tagged shared reorder queue. Requests enter in arrival
// order and leave in the order the selector chooses, with per-tag order kept.
// One ready signal upstream drops only when full. Assumes the tag carries
// the initiator ID.
module rsq_tagged_queue
    import rsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [1:0]        req_cls,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [TAG_W-1:0]  mem_tag,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [1:0]        mem_cls
);
    logic [DEPTH-1:0]             vld;
    logic [DEPTH-1:0][TAG_W-1:0]  tags;
    logic [DEPTH-1:0][ADDR_W-1:0] addrs;
    logic [DEPTH-1:0]             wes;
    logic [DEPTH-1:0][CLS_W-1:0]  clss;
    logic [DEPTH-1:0]             elig;
    logic [DEPTH-1:0]             grant;
    logic                         full;
    logic                         any;
    logic [IDX_W-1:0]             sel;
    logic                         enq;
    logic                         deq;

    assign req_ready = !full;
    assign enq       = req_valid && req_ready;
    assign mem_valid = any;
    assign deq       = any && mem_ready;

    // Encode the one-hot grant into a slot index.
    always_comb begin
        sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) sel = IDX_W'(i);
        end
    end

    // Present the granted slot's payload downstream.
    assign mem_tag  = tags[sel];
    assign mem_addr = addrs[sel];
    assign mem_we   = wes[sel];
    assign mem_cls  = clss[sel];

    rsq_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .enq(enq), .enq_tag(req_tag), .enq_addr(req_addr), .enq_we(req_we), .enq_cls(req_cls),
        .deq(deq), .deq_idx(sel),
        .vld(vld), .tags(tags), .addrs(addrs), .wes(wes), .clss(clss), .full(full)
    );

    rsq_elig #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_elig (
        .clk(clk), .rst_n(rst_n), .vld(vld), .tags(tags), .elig(elig)
    );

    rsq_pick #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig), .clss(clss), .grant(grant), .any(any)
    );

    // R5: a non-empty queue always presents an entry.
    a_r5_busy_presents: assert property (@(posedge clk) disable iff (!rst_n)
        vld[0] |-> mem_valid);

    // R4: a full queue with no removal is still full on the next cycle.
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !deq) |=> !req_ready);
endmodule

// File: tb/rsq_tagged_queue_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic. Every cycle the
// outputs are compared against a reference queue kept in the bench.
module rsq_tagged_queue_test;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_we = 0, mem_ready = 0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_cls = '0;
    logic req_ready, mem_valid, mem_we;
    logic [TAG_W-1:0] mem_tag;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0] mem_cls;

    int n_checks = 0;
    int n_fail = 0;

    // Reference queue, index 0 = oldest.
    int m_n = 0;
    int m_tag[DEPTH];
    int m_addr[DEPTH];
    int m_we[DEPTH];
    int m_cls[DEPTH];

    always #2 clk = ~clk;

    rsq_tagged_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_addr(req_addr), .req_we(req_we), .req_cls(req_cls),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_tag(mem_tag),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_cls(mem_cls)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected pick: oldest among the highest-class entries whose tag has no older entry.
    function automatic int model_pick();
        int best = -1;
        for (int i = 0; i < m_n; i++) begin
            bit blk = 0;
            for (int j = 0; j < i; j++) if (m_tag[j] == m_tag[i]) blk = 1;
            if (!blk && (best < 0 || m_cls[i] > m_cls[best])) best = i;
        end
        return best;
    endfunction

    // Compare the current outputs with the reference (called at a negative edge).
    task automatic compare_all();
        int p = model_pick();
        check("R4 ready", req_ready, m_n < DEPTH);
        check("R5 valid", mem_valid, m_n > 0);
        if (m_n > 0) begin
            check("R1/R2/R6/R7 payload", {mem_tag, mem_addr, mem_we, mem_cls},
                  {TAG_W'(m_tag[p]), ADDR_W'(m_addr[p]), 1'(m_we[p]), 2'(m_cls[p])});
        end
    endtask

    // One cycle: check, drive, update the reference, advance to the next negative edge.
    task automatic step(input bit iv, input int tg, input int ad, input bit w, input int c, input bit ordy);
        int p;
        bit hs_in, hs_out;
        compare_all();
        req_valid = iv; req_tag = TAG_W'(tg); req_addr = ADDR_W'(ad);
        req_we = w; req_cls = 2'(c); mem_ready = ordy;
        hs_in  = iv && (m_n < DEPTH);
        hs_out = ordy && (m_n > 0);
        p = model_pick();
        if (hs_out) begin
            for (int i = p; i < m_n - 1; i++) begin
                m_tag[i] = m_tag[i+1]; m_addr[i] = m_addr[i+1];
                m_we[i] = m_we[i+1]; m_cls[i] = m_cls[i+1];
            end
            m_n--;
        end
        if (hs_in) begin
            m_tag[m_n] = tg; m_addr[m_n] = ad; m_we[m_n] = w; m_cls[m_n] = c;
            m_n++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; mem_ready = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R5: reset leaves the queue empty.
        check("R5 reset ready", req_ready, 1);
        check("R5 reset valid", mem_valid, 0);

        // R9/R2: tag 0 keeps order even when the younger entry has a higher class.
        step(1, 0, 16'h0001, 0, 0, 0);
        step(1, 0, 16'h0002, 0, 2, 0);
        check("R9 tag0 order", mem_addr, 16'h0001);
        // R3: another tag with a higher class passes the older entries.
        step(1, 1, 16'h0003, 1, 2, 0);
        check("R3 bypass", mem_addr, 16'h0003);
        // R7: a second priority entry is younger, so the older one stays presented.
        step(1, 2, 16'h0004, 0, 2, 0);
        check("R7 oldest in class", mem_addr, 16'h0003);
        step(1, 3, 16'h0005, 0, 1, 0);
        step(1, 4, 16'h0006, 0, 0, 0);
        step(1, 5, 16'h0007, 0, 0, 0);
        step(1, 6, 16'h0008, 0, 0, 0);
        check("R4 full", req_ready, 0);
        // R4: an offer while full is ignored.
        step(1, 7, 16'h0009, 0, 3, 0);
        check("R4 ignored", mem_addr, 16'h0003);
        check("R4 still full", req_ready, 0);
        // R8: a removal frees a slot for the next cycle.
        step(0, 0, 0, 0, 0, 1);
        check("R8 slot freed", req_ready, 1);
        check("R6 next priority", mem_addr, 16'h0004);
        // R8: accept and remove together keep the occupancy.
        step(1, 7, 16'h000A, 0, 0, 1);
        check("R8 swap count", req_ready, 1);
        check("R6 bw over best", mem_addr, 16'h0005);
        step(0, 0, 0, 0, 0, 1);
        check("R7 oldest best", mem_addr, 16'h0001);
        step(0, 0, 0, 0, 0, 1);
        check("R2 tag0 released", mem_addr, 16'h0002);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1);
        check("R5 drained", mem_valid, 0);

        // Random traffic with a sweep of drain rates (R1, R2, R3, R6, R7).
        for (int ph = 0; ph < 4; ph++) begin
            for (int k = 0; k < 1000; k++) begin
                int pr = (ph == 0) ? 20 : (ph == 1) ? 50 : (ph == 2) ? 90 : 35;
                step($urandom_range(0, 99) < 70, $urandom_range(0, 3), $urandom_range(0, 65535),
                     $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 99) < pr);
            end
        end
        while (m_n > 0) step(0, 0, 0, 0, 0, 1);
        compare_all();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule